// File: doc/BRIEF.md
# UART Receive Frame Buffer with Blocking

This block sits between a UART receiver front end and the software read path. Each time the front end finishes a frame it presents the data byte together with parity-error, framing-error and address-frame markers for one cycle. The block keeps accepted frames, with their markers, in a two-slot FIFO. A third holding stage, standing in for the receive shift register, keeps one more frame while both slots are occupied. Software reads the oldest frame through a valid/ready read port. Single-cycle event pulses report a frame load, an overflow, and parity or framing errors.

A blocking mode lets the receiver go on sampling frames without handing them to software, so that external frame-recognition logic can watch the line. While blocking is on, completed frames are not loaded. The exception is an error-free address frame in multiprocessor mode, which is loaded anyway. Blocked frames with errors are dropped and raise no error events. A frame that completed before blocking began and is waiting in the holding stage is still committed once a slot frees up. A clear command empties both slots and the holding stage. A frame that completes in the same cycle as the clear lands in the emptied buffer.

The read port follows valid/ready rules. `rd_valid` is high whenever at least one slot is occupied. `rd_data` and the status bits show the oldest frame. That frame is removed on a cycle in which both `rd_valid` and `rd_ready` are high. The input side carries `in_valid` with no ready, because a receiver cannot pause a line. In place of back-pressure it has the holding stage and the overflow event.

Top module: `urxb_top`

## Requirements
- R1: Accepted frames leave in arrival order. Two FIFO slots plus one holding stage keep up to three frames. `rd_valid` is high exactly when a slot is occupied. The head frame is removed on a rising clock edge that sees `rd_valid && rd_ready`.
- R2: `cmd_block_on` sets `blocked` on the next cycle, and `cmd_block_off` clears it. When both are high, set wins.
- R3: A frame completing while the holding stage is occupied, and no slot frees up in that cycle, raises `ev_ovf` for one cycle on the next cycle, and the pending frame is lost. This applies even while blocked.
- R4: While blocked, a completed frame that is not an error-free address frame in multiprocessor mode is not loaded and raises no `ev_load`.
- R5: With `mp_mode` high, an error-free frame with `in_addr` high is loaded even while blocked.
- R6: While blocked, a frame with `in_perr` or `in_ferr` high is discarded, even when it is an address frame, and raises neither `ev_perr` nor `ev_ferr`.
- R7: An accepted frame with `in_perr` or `in_ferr` high pulses the matching event on the next cycle. The frame is stored with its markers: `rd_perr`, `rd_ferr` and `rd_addr` repeat the frame's `in_perr`, `in_ferr` and `in_addr`.
- R8: A frame waiting in the holding stage moves into the FIFO on the first cycle a slot frees up, whatever the blocking state.
- R9: `cmd_clear` empties both slots and the holding stage. A read in the same cycle has no effect. A frame completing in the same cycle is then judged under the normal rules and lands in the emptied FIFO.
- R10: Whether a frame is accepted depends on `blocked` as it stands in the cycle the frame completes. A block command in that same cycle does not affect it.
- R11: `ev_load` pulses one cycle after any frame is written into a FIFO slot, whether from the input or from the holding stage.
- R12: After reset the buffer is empty, `blocked` is low and every event output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mp_mode | input | 1 | Multiprocessor mode: address frames pass through blocking |
| cmd_block_on | input | 1 | Command pulse: start blocking |
| cmd_block_off | input | 1 | Command pulse: stop blocking |
| cmd_clear | input | 1 | Command pulse: empty slots and holding stage |
| in_valid | input | 1 | A frame completed this cycle |
| in_data | input | DW | Frame data |
| in_perr | input | 1 | Frame has a parity error |
| in_ferr | input | 1 | Frame has a framing error |
| in_addr | input | 1 | Frame is an address frame |
| rd_valid | output | 1 | At least one frame is available |
| rd_ready | input | 1 | Reader takes the head frame |
| rd_data | output | DW | Head frame data |
| rd_perr | output | 1 | Head frame parity-error marker |
| rd_ferr | output | 1 | Head frame framing-error marker |
| rd_addr | output | 1 | Head frame address marker |
| blocked | output | 1 | Blocking mode is on |
| ev_load | output | 1 | Pulse: a frame entered a FIFO slot |
| ev_ovf | output | 1 | Pulse: a pending frame was overwritten |
| ev_perr | output | 1 | Pulse: an accepted frame had a parity error |
| ev_ferr | output | 1 | Pulse: an accepted frame had a framing error |

## Verification
Two pairs of functions can fall in the same cycle. A clear can coincide with both a read and a frame completion. A read that frees a slot can coincide with a new frame arriving while the holding stage is full, and that new frame may itself be blocked. Directed steps force each of these collisions. In the first, the emptied buffer must show only the new frame. In the second, the pending frame must be committed with no overflow, and the new frame must take over the holding stage. The random phase then mixes all commands with fixed-seed traffic. A bench reference queue predicts data, `rd_valid` and every event on each cycle.

// File: rtl/urxb_pkg.sv
package urxb_pkg;
  // Markers carried with each frame through every storage stage.
  typedef struct packed {
    logic addr;
    logic ferr;
    logic perr;
  } rx_stat_t;
endpackage

// File: rtl/urxb_blockflag.sv
module urxb_blockflag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic blocked_o
);
  // Set has priority over clear when both commands arrive together.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     blocked_o <= 1'b0;
    else if (set_i) blocked_o <= 1'b1;
    else if (clr_i) blocked_o <= 1'b0;
  end
endmodule

// File: rtl/urxb_admit.sv
module urxb_admit (
  input  logic blocked_i,
  input  logic mp_mode_i,
  input  logic valid_i,
  input  logic perr_i,
  input  logic ferr_i,
  input  logic addr_i,
  output logic accept_o,
  output logic perr_ev_o,
  output logic ferr_ev_o
);
  logic clean;
  logic bypass;

  always_comb begin
    clean     = !perr_i && !ferr_i;
    // Only a clean address frame in multiprocessor mode passes the block.
    bypass    = mp_mode_i && addr_i && clean;
    accept_o  = valid_i && (!blocked_i || bypass);
    perr_ev_o = accept_o && perr_i;
    ferr_ev_o = accept_o && ferr_i;
  end
endmodule

// File: rtl/urxb_hold.sv
module urxb_hold #(
  parameter int DW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic                vacate_i,
  input  logic [DW-1:0]       data_i,
  input  urxb_pkg::rx_stat_t  stat_i,
  output logic                valid_o,
  output logic [DW-1:0]       data_o,
  output urxb_pkg::rx_stat_t  stat_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      stat_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
      stat_o  <= stat_i;
    end else if (vacate_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/urxb_fifo.sv
module urxb_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush_i,
  input  logic                wr_i,
  input  logic [DW-1:0]       wr_data_i,
  input  urxb_pkg::rx_stat_t  wr_stat_i,
  input  logic                rd_i,
  output logic [DW-1:0]       rd_data_o,
  output urxb_pkg::rx_stat_t  rd_stat_o,
  output logic                nonempty_o,
  output logic                full_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [PW-1:0] rd_ptr, wr_ptr, wr_idx;
  logic [CW-1:0] cnt;
  logic [DW-1:0] slot_data [DEPTH];
  urxb_pkg::rx_stat_t slot_stat [DEPTH];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : PW'(p + 1'b1);
  endfunction

  // A flush restarts the pointers, so a write in the same cycle lands in slot 0.
  assign wr_idx = flush_i ? '0 : wr_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else if (flush_i) begin
      rd_ptr <= '0;
      wr_ptr <= wr_i ? bump('0) : '0;
      cnt    <= wr_i ? CW'(1) : '0;
    end else begin
      if (rd_i) rd_ptr <= bump(rd_ptr);
      if (wr_i) wr_ptr <= bump(wr_ptr);
      case ({wr_i, rd_i})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [DW-1:0]      d_q;
    urxb_pkg::rx_stat_t s_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        d_q <= '0;
        s_q <= '0;
      end else if (wr_i && wr_idx == PW'(i)) begin
        d_q <= wr_data_i;
        s_q <= wr_stat_i;
      end
    end
    assign slot_data[i] = d_q;
    assign slot_stat[i] = s_q;
  end

  assign rd_data_o  = slot_data[rd_ptr];
  assign rd_stat_o  = slot_stat[rd_ptr];
  assign nonempty_o = (cnt != '0);
  assign full_o     = (cnt == CW'(DEPTH));
endmodule

// File: rtl/urxb_top.sv
module urxb_top #(
  parameter int DW    = 8,
  parameter int DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mp_mode,
  input  logic          cmd_block_on,
  input  logic          cmd_block_off,
  input  logic          cmd_clear,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          in_perr,
  input  logic          in_ferr,
  input  logic          in_addr,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_data,
  output logic          rd_perr,
  output logic          rd_ferr,
  output logic          rd_addr,
  output logic          blocked,
  output logic          ev_load,
  output logic          ev_ovf,
  output logic          ev_perr,
  output logic          ev_ferr
);
  import urxb_pkg::*;

  logic     accept, perr_ev, ferr_ev;
  logic     fifo_full, pop, room, hold_live;
  logic     move, direct, to_hold, drop_hold, ovf, fifo_wr;
  logic     hold_v;
  logic [DW-1:0] hold_d, wr_data;
  rx_stat_t hold_s, in_stat, wr_stat, head_s;

  assign in_stat = '{addr: in_addr, ferr: in_ferr, perr: in_perr};

  urxb_blockflag u_blk (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (cmd_block_on),
    .clr_i     (cmd_block_off),
    .blocked_o (blocked)
  );

  // Admission uses the block state of the completing cycle (R10).
  urxb_admit u_admit (
    .blocked_i (blocked),
    .mp_mode_i (mp_mode),
    .valid_i   (in_valid),
    .perr_i    (in_perr),
    .ferr_i    (in_ferr),
    .addr_i    (in_addr),
    .accept_o  (accept),
    .perr_ev_o (perr_ev),
    .ferr_ev_o (ferr_ev)
  );

  // Clear acts first, then a read, then the holding stage, then the new frame.
  always_comb begin
    pop       = rd_valid && rd_ready && !cmd_clear;
    room      = cmd_clear || pop || !fifo_full;
    hold_live = hold_v && !cmd_clear;
    move      = hold_live && room;
    direct    = accept && !hold_live && room;
    to_hold   = accept && (hold_live || !room);
    ovf       = hold_live && !room && in_valid;
    drop_hold = ovf && !accept;
    fifo_wr   = move || direct;
    wr_data   = move ? hold_d : in_data;
    wr_stat   = move ? hold_s : in_stat;
  end

  urxb_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush_i    (cmd_clear),
    .wr_i       (fifo_wr),
    .wr_data_i  (wr_data),
    .wr_stat_i  (wr_stat),
    .rd_i       (pop),
    .rd_data_o  (rd_data),
    .rd_stat_o  (head_s),
    .nonempty_o (rd_valid),
    .full_o     (fifo_full)
  );

  urxb_hold #(.DW(DW)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (to_hold),
    .vacate_i (cmd_clear || move || drop_hold),
    .data_i   (in_data),
    .stat_i   (in_stat),
    .valid_o  (hold_v),
    .data_o   (hold_d),
    .stat_o   (hold_s)
  );

  assign rd_perr = head_s.perr;
  assign rd_ferr = head_s.ferr;
  assign rd_addr = head_s.addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_load <= 1'b0;
      ev_ovf  <= 1'b0;
      ev_perr <= 1'b0;
      ev_ferr <= 1'b0;
    end else begin
      ev_load <= fifo_wr;
      ev_ovf  <= ovf;
      ev_perr <= perr_ev;
      ev_ferr <= ferr_ev;
    end
  end
endmodule

// File: rtl/urxb_top_chk.sv
module urxb_top_chk (
  input logic clk,
  input logic rst_n,
  input logic mp_mode,
  input logic cmd_block_on,
  input logic cmd_block_off,
  input logic cmd_clear,
  input logic in_valid,
  input logic in_perr,
  input logic in_ferr,
  input logic in_addr,
  input logic rd_valid,
  input logic blocked,
  input logic ev_load,
  input logic ev_ovf,
  input logic ev_perr,
  input logic ev_ferr,
  input logic hold_v
);
  p_block_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_block_on |=> blocked);

  p_block_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_block_off && !cmd_block_on |=> !blocked);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_v |=> !ev_ovf);

  p_blocked_no_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    blocked && in_valid && !(mp_mode && in_addr) && !hold_v |=> !ev_load);

  p_blocked_err_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    blocked && in_valid && (in_perr || in_ferr) |=> !ev_perr && !ev_ferr);

  p_hold_needs_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_v |-> rd_valid);

  p_clear_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_clear && !in_valid |=> !rd_valid && !hold_v);

  p_load_visible_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load |-> rd_valid);
endmodule

bind urxb_top urxb_top_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mp_mode       (mp_mode),
  .cmd_block_on  (cmd_block_on),
  .cmd_block_off (cmd_block_off),
  .cmd_clear     (cmd_clear),
  .in_valid      (in_valid),
  .in_perr       (in_perr),
  .in_ferr       (in_ferr),
  .in_addr       (in_addr),
  .rd_valid      (rd_valid),
  .blocked       (blocked),
  .ev_load       (ev_load),
  .ev_ovf        (ev_ovf),
  .ev_perr       (ev_perr),
  .ev_ferr       (ev_ferr),
  .hold_v        (hold_v)
);

// File: tb/urxb_top_tb.sv
module urxb_top_tb;
  localparam int DW      = 8;
  localparam int DEPTH   = 2;
  localparam int CLK_PER = 10;
  localparam int WD_CYC  = 100000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mp_mode = 1'b0, cmd_block_on = 1'b0, cmd_block_off = 1'b0, cmd_clear = 1'b0;
  logic in_valid = 1'b0, in_perr = 1'b0, in_ferr = 1'b0, in_addr = 1'b0, rd_ready = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic rd_valid, rd_perr, rd_ferr, rd_addr, blocked, ev_load, ev_ovf, ev_perr, ev_ferr;
  logic [DW-1:0] rd_data;

  int checks = 0, fails = 0;

  // Reference state: word = {addr, ferr, perr, data}.
  logic [DW+2:0] mq[$];
  logic [DW+2:0] mh;
  logic mh_v = 1'b0, m_blk = 1'b0;
  logic e_load, e_ovf, e_perr, e_ferr;

  always #(CLK_PER/2) clk = ~clk;

  urxb_top #(.DW(DW), .DEPTH(DEPTH)) u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic admit(input logic blk, input logic mp, input logic v,
                                 input logic pe, input logic fe, input logic ad);
    return v && (!blk || (mp && ad && !pe && !fe));
  endfunction

  task automatic model(input logic v, input logic [DW+2:0] w, input logic rr,
                       input logic on, input logic off, input logic clr);
    logic acc;
    acc = admit(m_blk, mp_mode, v, w[DW], w[DW+1], w[DW+2]);
    e_load = 0; e_ovf = 0;
    e_perr = acc && w[DW];
    e_ferr = acc && w[DW+1];
    if (clr) begin mq.delete(); mh_v = 0; end
    else if (rr && mq.size() > 0) void'(mq.pop_front());
    if (mh_v && mq.size() < DEPTH) begin mq.push_back(mh); mh_v = 0; e_load = 1; end
    else if (mh_v && v) begin e_ovf = 1; mh_v = 0; end
    if (acc) begin
      if (mq.size() < DEPTH) begin mq.push_back(w); e_load = 1; end
      else begin mh = w; mh_v = 1; end
    end
    if (on) m_blk = 1; else if (off) m_blk = 0;
  endtask

  task automatic step(input logic v, input logic [DW-1:0] d, input logic pe, input logic fe,
                      input logic ad, input logic rr, input logic on, input logic off,
                      input logic clr);
    in_valid = v; in_data = d; in_perr = pe; in_ferr = fe; in_addr = ad;
    rd_ready = rr; cmd_block_on = on; cmd_block_off = off; cmd_clear = clr;
    @(posedge clk); #1;
    model(v, {ad, fe, pe, d}, rr, on, off, clr);
    in_valid = 0; rd_ready = 0; cmd_block_on = 0; cmd_block_off = 0; cmd_clear = 0;
    chk("R1 rd_valid", 32'(rd_valid), 32'(mq.size() > 0));
    if (mq.size() > 0) chk("R1/R7 head", 32'({rd_addr, rd_ferr, rd_perr, rd_data}), 32'(mq[0]));
    chk("R2 blocked", 32'(blocked), 32'(m_blk));
    chk("R11 ev_load", 32'(ev_load), 32'(e_load));
    chk("R3 ev_ovf", 32'(ev_ovf), 32'(e_ovf));
    chk("R7 ev_perr", 32'(ev_perr), 32'(e_perr));
    chk("R7 ev_ferr", 32'(ev_ferr), 32'(e_ferr));
  endtask

  initial begin
    #(CLK_PER * WD_CYC);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    // R12: reset state
    chk("R12 rd_valid", 32'(rd_valid), 0);
    chk("R12 blocked", 32'(blocked), 0);
    chk("R12 events", 32'({ev_load, ev_ovf, ev_perr, ev_ferr}), 0);
    mp_mode = 1'b1;
    // Fill two slots and the holding stage
    step(1, 8'h11, 0, 0, 0, 0, 0, 0, 0);
    chk("R11 first load", 32'(ev_load), 1);
    step(1, 8'h22, 1, 0, 0, 0, 0, 0, 0);
    chk("R7 parity event", 32'(ev_perr), 1);
    step(1, 8'h33, 0, 0, 0, 0, 0, 0, 0);
    chk("R1 third stage no load", 32'(ev_load), 0);
    chk("R1 head oldest", 32'(rd_data), 32'h11);
    step(1, 8'h44, 0, 0, 0, 0, 0, 0, 0);
    chk("R3 overflow", 32'(ev_ovf), 1);
    // Read frees a slot while a new frame lands in the holding stage
    step(1, 8'h45, 0, 0, 0, 1, 0, 0, 0);
    chk("R8 commit no overflow", 32'({ev_load, ev_ovf}), 32'b10);
    chk("R7 stored parity", 32'({rd_perr, rd_data}), 32'h122);
    step(0, 0, 0, 0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 1, 0, 0);
    chk("R2 block set", 32'(blocked), 1);
    step(0, 0, 0, 0, 0, 1, 0, 0, 0);
    // Buffer now empty and blocked
    step(1, 8'h55, 0, 0, 0, 0, 0, 0, 0);
    chk("R4 blocked frame dropped", 32'({ev_load, rd_valid}), 0);
    step(1, 8'h66, 0, 1, 1, 0, 0, 0, 0);
    chk("R6 blocked error silent", 32'({ev_ferr, ev_load}), 0);
    step(1, 8'h77, 0, 0, 1, 0, 0, 0, 0);
    chk("R5 address bypass", 32'({ev_load, rd_addr, rd_data}), 32'h377);
    // Pending frame committed after blocking starts
    step(0, 0, 0, 0, 0, 0, 0, 1, 0);
    step(1, 8'h88, 0, 0, 0, 0, 0, 0, 0);
    step(1, 8'h99, 0, 0, 0, 0, 1, 0, 0);
    chk("R10 same-cycle block accepts", 32'(ev_load), 0);
    step(1, 8'hA0, 0, 0, 0, 0, 0, 0, 0);
    chk("R3 overflow while blocked", 32'(ev_ovf), 1);
    step(0, 0, 0, 0, 0, 1, 0, 0, 0);
    chk("R8 no pending after blocked overwrite", 32'(ev_load), 0);
    step(0, 0, 0, 0, 0, 0, 0, 1, 0);
    step(1, 8'hB0, 0, 0, 0, 0, 0, 0, 0);
    step(1, 8'hB1, 0, 0, 0, 0, 1, 0, 0);
    chk("R10 frame with block-on accepted", 32'({ev_load, blocked}), 32'b01);
    step(0, 0, 0, 0, 0, 1, 0, 0, 0);
    chk("R8 commit while blocked", 32'(ev_load), 1);
    // Clear with read and a frame in the same cycle
    step(1, 8'hC3, 0, 0, 1, 1, 0, 0, 1);
    chk("R9 clear keeps new frame", 32'({rd_valid, rd_data}), 32'h1C3);
    step(0, 0, 0, 0, 0, 1, 0, 0, 0);
    chk("R9 only one frame", 32'(rd_valid), 0);
    // Random phase
    for (int i = 0; i < 6000; i++) begin
      if ($urandom % 200 == 0) mp_mode = ~mp_mode;
      step(($urandom % 2) == 0, DW'($urandom), ($urandom % 8) == 0, ($urandom % 8) == 0,
           ($urandom % 4) == 0, ($urandom % 3) == 0, ($urandom % 16) == 0,
           ($urandom % 12) == 0, ($urandom % 64) == 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule